// File: doc/BRIEF.md
# Command Port Decoder for a Tile Video Controller

This block sits behind the command port of a tile-based video display controller. Each 16-bit word written to the port is decoded in one of two ways. It can be a single-word write of one internal 8-bit setting register. It can also be one half of a two-word command that assembles a 16-bit target address and a 6-bit access code for later data-port transfers.

Between the two halves of a command, a pending flag is set. A data-port access or a status read cancels the pending flag, which lets software resynchronise the port. A read of the command port returns a status word. It is built from a fixed base pattern and the empty and full indications of the write FIFO.

The address register advances by the value held in the auto-increment setting register whenever the surrounding data-port logic signals a completed access.

Top module: `cmd_port_decoder`

## Requirements
- R1: With no command pending, a valid word whose bits [15:14] are 2'b10 writes bits [7:0] into the setting register selected by bits [12:8]. Address, code and the pending flag are left unchanged.
- R2: A register-write word whose index is not below NUM_REGS changes no setting register, no address bit, no code bit and no pending state.
- R3: With no command pending, any other valid word is a first command word. Bits [13:0] go to address[13:0] and bits [15:14] go to code[1:0]. Address[15:14] and code[5:2] are kept, and pending is set.
- R4: With a command pending, the next valid word is always taken as the second command word, whatever its top bits. Bits [1:0] go to address[15:14] and bits [5:2] go to code[5:2]. The low address and code bits are kept, and pending is cleared.
- R5: A data-access pulse or a status read clears pending. A command word arriving in the same cycle as one of these is decoded as if nothing were pending.
- R6: The status output is combinational and equals 16'h3400, with bit 9 set when the FIFO is empty and bit 8 set when it is full.
- R7: Synchronous reset clears all setting registers, the address, the code and the pending flag.
- R8: An increment pulse adds the value of setting register AUTOINC_IDX (default 15) to the address, modulo 2^16. A first or second command word in the same cycle takes precedence and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command-port write strobe |
| cmd_word | input | 16 | Word written to the command port |
| stat_rd | input | 1 | Command-port (status) read strobe |
| data_access | input | 1 | Pulse for any data-port read or write |
| addr_inc | input | 1 | Completed data access; advance address |
| fifo_empty | input | 1 | Write FIFO empty |
| fifo_full | input | 1 | Write FIFO full |
| status | output | 16 | Status word |
| addr | output | 16 | Current target address |
| code | output | 6 | Current access code |
| pending | output | 1 | Second command word expected |
| regs_flat | output | NUM_REGS*8 | All setting registers, register i at bits [8i+7:8i] |

## Verification
A word with the register-write prefix that arrives while pending is the sharpest case. A design that checks the prefix first would corrupt a setting register and leave pending set, instead of completing the address. Coincident clear-and-write cycles are driven as well. If the clear were applied after decoding, the word would be taken as a second half. An out-of-range register index is sent to catch a design that wraps the index onto a real register. Address wrap at 16'hFFFF and the retention of the low address bits across the second word are also covered. Without these, a design could zero or sign-extend the low address bits without being caught.

// File: rtl/cmdport_pkg.sv
`timescale 1ns/1ps
package cmdport_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 16;
    localparam int CODE_W = 6;
    localparam int REG_W  = 8;
    localparam int IDX_W  = 5;
    localparam int LOW_ADDR_W = 14;

    localparam logic [WORD_W-1:0] STATUS_BASE = 16'h3400;
    localparam int ST_EMPTY_BIT = 9;
    localparam int ST_FULL_BIT  = 8;
    localparam logic [1:0] REG_PREFIX = 2'b10;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_REG,
        WK_FIRST,
        WK_SECOND
    } word_kind_e;

    typedef struct packed {
        word_kind_e         kind;
        logic [WORD_W-1:0]  word;
    } cmd_dec_t;

    function automatic word_kind_e classify(
        input logic [WORD_W-1:0] w,
        input logic              valid,
        input logic              pend_eff,
        input logic              idx_ok
    );
        if (!valid)                     return WK_NONE;
        if (pend_eff)                   return WK_SECOND;
        if (w[15:14] == REG_PREFIX)     return idx_ok ? WK_REG : WK_NONE;
        return WK_FIRST;
    endfunction
endpackage

// File: rtl/cmd_classify.sv
`timescale 1ns/1ps
module cmd_classify
    import cmdport_pkg::*;
#(
    parameter int NUM_REGS = 24
) (
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              pending,
    input  logic              clr,
    output cmd_dec_t          dec
);
    logic pend_eff;
    logic idx_ok;

    always_comb begin
        pend_eff  = pending & ~clr;
        idx_ok    = 32'(cmd_word[12:8]) < NUM_REGS;
        dec.kind  = classify(cmd_word, cmd_valid, pend_eff, idx_ok);
        dec.word  = cmd_word;
    end
endmodule

// File: rtl/reg_bank.sv
`timescale 1ns/1ps
module reg_bank
    import cmdport_pkg::*;
#(
    parameter int NUM_REGS = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  logic [REG_W-1:0]          wval,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [REG_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && widx == IDX_W'(i))
                q <= wval;
        end
        assign regs_flat[i*REG_W +: REG_W] = q;
    end
endmodule

// File: rtl/addr_code_reg.sv
`timescale 1ns/1ps
module addr_code_reg
    import cmdport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_dec_t          dec,
    input  logic              clr,
    input  logic              addr_inc,
    input  logic [REG_W-1:0]  step,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] code,
    output logic              pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            code    <= '0;
            pending <= 1'b0;
        end else begin
            case (dec.kind)
                WK_FIRST: begin
                    addr[LOW_ADDR_W-1:0] <= dec.word[LOW_ADDR_W-1:0];
                    code[1:0]            <= dec.word[15:14];
                    pending              <= 1'b1;
                end
                WK_SECOND: begin
                    addr[ADDR_W-1:LOW_ADDR_W] <= dec.word[1:0];
                    code[CODE_W-1:2]          <= dec.word[5:2];
                    pending                   <= 1'b0;
                end
                default: begin
                    if (addr_inc)
                        addr <= addr + ADDR_W'(step);
                    if (clr)
                        pending <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/status_gen.sv
`timescale 1ns/1ps
module status_gen
    import cmdport_pkg::*;
(
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic [WORD_W-1:0] status
);
    always_comb begin
        status               = STATUS_BASE;
        status[ST_EMPTY_BIT] = fifo_empty;
        status[ST_FULL_BIT]  = fifo_full;
    end
endmodule

// File: rtl/cmd_port_decoder.sv
`timescale 1ns/1ps
module cmd_port_decoder
    import cmdport_pkg::*;
#(
    parameter int NUM_REGS    = 24,
    parameter int AUTOINC_IDX = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic [15:0]               cmd_word,
    input  logic                      stat_rd,
    input  logic                      data_access,
    input  logic                      addr_inc,
    input  logic                      fifo_empty,
    input  logic                      fifo_full,
    output logic [15:0]               status,
    output logic [15:0]               addr,
    output logic [5:0]                code,
    output logic                      pending,
    output logic [NUM_REGS*8-1:0]     regs_flat
);
    cmd_dec_t dec;
    logic     clr;
    logic     reg_we;

    assign clr    = data_access | stat_rd;
    assign reg_we = (dec.kind == WK_REG);

    cmd_classify #(.NUM_REGS(NUM_REGS)) u_classify (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .pending   (pending),
        .clr       (clr),
        .dec       (dec)
    );

    reg_bank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .widx      (dec.word[12:8]),
        .wval      (dec.word[7:0]),
        .regs_flat (regs_flat)
    );

    addr_code_reg u_addr (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .clr      (clr),
        .addr_inc (addr_inc),
        .step     (regs_flat[AUTOINC_IDX*REG_W +: REG_W]),
        .addr     (addr),
        .code     (code),
        .pending  (pending)
    );

    status_gen u_status (
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .status     (status)
    );
endmodule

// File: rtl/cmd_port_checker.sv
`timescale 1ns/1ps
module cmd_port_checker #(
    parameter int NUM_REGS    = 24,
    parameter int AUTOINC_IDX = 15
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_valid,
    input logic [15:0]           cmd_word,
    input logic                  stat_rd,
    input logic                  data_access,
    input logic                  addr_inc,
    input logic                  fifo_empty,
    input logic                  fifo_full,
    input logic [15:0]           status,
    input logic [15:0]           addr,
    input logic [5:0]            code,
    input logic                  pending,
    input logic [NUM_REGS*8-1:0] regs_flat
);
    logic [7:0] step;
    logic       clr_ev;
    assign step   = regs_flat[AUTOINC_IDX*8 +: 8];
    assign clr_ev = stat_rd | data_access;

    // R3
    p_first_word_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !pending && cmd_word[15:14] != 2'b10
        |=> pending && addr[13:0] == $past(cmd_word[13:0]) && code[1:0] == $past(cmd_word[15:14]));

    // R4
    p_second_word_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && pending && !clr_ev
        |=> !pending && addr[15:14] == $past(cmd_word[1:0]) && addr[13:0] == $past(addr[13:0])
            && code == {$past(cmd_word[5:2]), $past(code[1:0])});

    // R5
    p_clear_pending_r5: assert property (@(posedge clk) disable iff (rst)
        clr_ev && !cmd_valid |=> !pending);

    // R2
    p_bad_index_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (!pending || clr_ev) && cmd_word[15:14] == 2'b10 && 32'(cmd_word[12:8]) >= NUM_REGS
        |=> $stable(regs_flat) && !pending && $stable(addr) && $stable(code));

    // R8
    p_increment_r8: assert property (@(posedge clk) disable iff (rst)
        addr_inc && !cmd_valid |=> addr == $past(addr) + 16'($past(step)));

    // R6
    p_status_word_r6: assert property (@(posedge clk) disable iff (rst)
        status[15:10] == 6'b001101 && status[7:0] == 8'h00
        && status[9] == fifo_empty && status[8] == fifo_full);
endmodule

bind cmd_port_decoder cmd_port_checker #(.NUM_REGS(NUM_REGS), .AUTOINC_IDX(AUTOINC_IDX)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .stat_rd(stat_rd),
    .data_access(data_access), .addr_inc(addr_inc), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .status(status), .addr(addr), .code(code), .pending(pending), .regs_flat(regs_flat)
);

// File: tb/sim_cmd_port_decoder.sv
`timescale 1ns/1ps
module sim_cmd_port_decoder;
    localparam int NREG = 24;
    localparam int NVEC = 13;
    localparam logic [1:0] OP_CMD = 2'd0, OP_STAT = 2'd1, OP_DATA = 2'd2, OP_INC = 2'd3;

    // {op, word, exp_addr, exp_code, exp_pending}
    localparam logic [40:0] VEC [NVEC] = '{
        {OP_CMD,  16'h8F02, 16'h0000, 6'h00, 1'b0},
        {OP_CMD,  16'h4123, 16'h0123, 6'h01, 1'b1},
        {OP_CMD,  16'h0016, 16'h8123, 6'h15, 1'b0},
        {OP_INC,  16'h0000, 16'h8125, 6'h15, 1'b0},
        {OP_CMD,  16'hC3FF, 16'h83FF, 6'h17, 1'b1},
        {OP_STAT, 16'h0000, 16'h83FF, 6'h17, 1'b0},
        {OP_CMD,  16'h8A55, 16'h83FF, 6'h17, 1'b0},
        {OP_CMD,  16'h0000, 16'h8000, 6'h14, 1'b1},
        {OP_CMD,  16'h8F3F, 16'hC000, 6'h3C, 1'b0},
        {OP_INC,  16'h0000, 16'hC002, 6'h3C, 1'b0},
        {OP_CMD,  16'h3FFF, 16'hFFFF, 6'h3C, 1'b1},
        {OP_DATA, 16'h0000, 16'hFFFF, 6'h3C, 1'b0},
        {OP_INC,  16'h0000, 16'h0001, 6'h3C, 1'b0}
    };

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, stat_rd = 0, data_access = 0, addr_inc = 0;
    logic fifo_empty = 0, fifo_full = 0;
    logic [15:0] cmd_word = '0;
    logic [15:0] status, addr;
    logic [5:0]  code;
    logic        pending;
    logic [NREG*8-1:0] regs_flat;
    logic [NREG*8-1:0] snap;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmd_port_decoder #(.NUM_REGS(NREG), .AUTOINC_IDX(15)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .stat_rd(stat_rd),
        .data_access(data_access), .addr_inc(addr_inc), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .status(status), .addr(addr), .code(code), .pending(pending), .regs_flat(regs_flat)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_op(input logic [1:0] op, input logic [15:0] w);
        cmd_valid   = (op == OP_CMD);
        stat_rd     = (op == OP_STAT);
        data_access = (op == OP_DATA);
        addr_inc    = (op == OP_INC);
        cmd_word    = w;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0; stat_rd = 0; data_access = 0; addr_inc = 0;
    endtask

    function automatic logic [7:0] reg_at(input int i);
        return regs_flat[i*8 +: 8];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R7: reset state
        chk("R7 addr", 64'(addr), 0);
        chk("R7 code", 64'(code), 0);
        chk("R7 pending", 64'(pending), 0);
        chk("R7 regs", 64'(regs_flat == '0), 1);

        // R1 R3 R4 R5 R8: vector walk
        for (int i = 0; i < NVEC; i++) begin
            step_op(VEC[i][40:39], VEC[i][38:23]);
            chk($sformatf("R3/R4/R5/R8 vec%0d addr", i), 64'(addr), 64'(VEC[i][22:7]));
            chk($sformatf("R3/R4 vec%0d code", i), 64'(code), 64'(VEC[i][6:1]));
            chk($sformatf("R3/R4/R5 vec%0d pending", i), 64'(pending), 64'(VEC[i][0]));
        end
        // R1: register writes landed; R4: pending 0x8F3F did not touch reg 15
        chk("R1 reg10", 64'(reg_at(10)), 64'h55);
        chk("R1/R4 reg15", 64'(reg_at(15)), 64'h02);

        // R2: out-of-range index
        snap = regs_flat;
        step_op(OP_CMD, 16'h9F77);
        chk("R2 regs", 64'(regs_flat == snap), 1);
        chk("R2 pending", 64'(pending), 0);
        chk("R2 addr", 64'(addr), 64'h0001);
        step_op(OP_CMD, 16'h9877);   // index 24, first out-of-range
        chk("R2 idx24 regs", 64'(regs_flat == snap), 1);

        // R5: command word with same-cycle status read is decoded as non-pending
        step_op(OP_CMD, 16'h0123);
        chk("R5 setup pending", 64'(pending), 1);
        cmd_valid = 1; stat_rd = 1; cmd_word = 16'h8312;
        @(posedge clk); @(negedge clk);
        cmd_valid = 0; stat_rd = 0;
        chk("R5 same-cycle reg3", 64'(reg_at(3)), 64'h12);
        chk("R5 same-cycle pending", 64'(pending), 0);
        chk("R5 same-cycle addr", 64'(addr), 64'h0123);

        // R8: command word beats increment in same cycle
        cmd_valid = 1; addr_inc = 1; cmd_word = 16'h0200;
        @(posedge clk); @(negedge clk);
        cmd_valid = 0; addr_inc = 0;
        chk("R8 precedence addr", 64'(addr), 64'h0200);

        // R6: status combinations
        for (int k = 0; k < 4; k++) begin
            fifo_empty = k[0]; fifo_full = k[1];
            #1;
            chk("R6 status", 64'(status), 64'(16'h3400 | (k[0] ? 16'h0200 : 16'h0) | (k[1] ? 16'h0100 : 16'h0)));
        end

        // R7: reset mid-run
        @(negedge clk);
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        chk("R7 mid addr", 64'(addr), 0);
        chk("R7 mid pending", 64'(pending), 0);
        chk("R7 mid regs", 64'(regs_flat == '0), 1);

        finish_run();
    end
endmodule